// File: doc/BRIEF.md
# Transfer Acknowledge Generator

This block sits beside a cache tag store and decides, every cycle, whether the processor bus should see a transfer acknowledge. It takes the raw tag compare result and the valid and write-through status bits read from the addressed entry, together with a set of control inputs. From these it drives an active-low acknowledge value plus an output enable that stands in for a tri-stated pin.

When the enable input is high, the acknowledge is released. An external acknowledge request is captured on the rising clock edge and overrides all other sources. Direct accesses to the tag or status array suppress the acknowledge, and so does a force-high request unless the entry hits. In dedicated status mode, an invalid entry or a write transfer to a write-through entry also suppresses it. Otherwise the acknowledge follows the compare. In generic status mode the status bits play no part, and a compare hit alone asserts the acknowledge.

Top module: `tack_gen`

## Requirements
- R1: While `ack_oe_n` is high, `ack_en` is 0 and `ack_n` reads 1, whatever the other inputs are.
- R2: `ext_ack_n` is sampled at each rising clock edge by a register that resets to 1 (inactive). While `ack_oe_n` is low and the sampled value is 0, `ack_n` is 0, regardless of every other input.
- R3: With the sampled external value 1 and `ack_oe_n` low, a low `tag_oe_n`, a low `tag_we_n` or a low `stat_we_n` makes `ack_n` 1.
- R4: With no access active and `force_hi` set, `ack_n` is 0 only for a qualified hit and 1 otherwise. A qualified hit is `hit` AND (`generic_mode` OR `vld`). A qualified hit wins over the write-through rule.
- R5: In dedicated mode (`generic_mode` = 0), when the entry's `vld` is 0 and the sampled external value is 1, `ack_n` is 1.
- R6: In dedicated mode, with no access and no force, `xfer_rd` = 0 (a write transfer) together with `wt` = 1 makes `ack_n` 1.
- R7: In generic mode (`generic_mode` = 1), with no access and the sampled external value 1, `ack_n` equals the inverse of `hit`, with `vld` and `wt` having no effect.
- R8: In dedicated mode, with no access, no force, `vld` = 1 and no write-through block, `ack_n` equals the inverse of `hit`.
- R9: While `rst_n` is low the sampled external value is held at 1, so an `ext_ack_n` of 0 applied during reset does not assert the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; external acknowledge sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_oe_n | input | 1 | Acknowledge output enable, active low |
| ext_ack_n | input | 1 | External acknowledge request, active low, synchronous |
| force_hi | input | 1 | Suppress acknowledge unless qualified hit |
| xfer_rd | input | 1 | Transfer type: 1 read, 0 write |
| generic_mode | input | 1 | 0 dedicated status meaning, 1 generic status bits |
| tag_oe_n | input | 1 | Tag read enable, active low |
| tag_we_n | input | 1 | Tag write enable, active low |
| stat_we_n | input | 1 | Status write enable, active low |
| hit | input | 1 | Raw tag compare result from the tag store |
| vld | input | 1 | Stored valid bit of the addressed entry |
| wt | input | 1 | Stored write-through bit of the addressed entry |
| ack_n | output | 1 | Acknowledge value, active low |
| ack_en | output | 1 | High when the acknowledge is driven |

## Verification
The bound checker looks at every cycle for the release under a high enable, for the override by the previous edge's external sample, and for the suppression under array accesses and invalid entries. It also checks the write-through block on writes, the force-high outcome on a qualified hit, and the generic-mode compare following. The reset hold on the sampled external request, and the full priority order across every combination of the eleven inputs, are shown only by the bench. It walks all 2048 input patterns and then random ones against its own priority-ordered reference.

// File: rtl/tack_pkg.sv
package tack_pkg;

  typedef enum logic [2:0] {
    SRC_OFF     = 3'd0,
    SRC_EXT     = 3'd1,
    SRC_ACCESS  = 3'd2,
    SRC_FORCE   = 3'd3,
    SRC_INVALID = 3'd4,
    SRC_WTHRU   = 3'd5,
    SRC_CMP     = 3'd6
  } tack_src_e;

endpackage

// File: rtl/tack_ext_sample.sv
module tack_ext_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic req_n,
  output logic req_q_n
);

  logic req_d_n;

  always_comb begin
    req_d_n = req_q_n;
    if (sample_en) req_d_n = req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q_n <= 1'b1;
    else        req_q_n <= req_d_n;
  end

endmodule

// File: rtl/tack_qualify.sv
module tack_qualify (
  input  logic generic_mode,
  input  logic hit,
  input  logic vld,
  input  logic wt,
  input  logic xfer_rd,
  output logic valid_hit,
  output logic entry_invalid,
  output logic wthru_block
);

  always_comb begin
    valid_hit     = hit & (generic_mode | vld);
    entry_invalid = ~generic_mode & ~vld;
    wthru_block   = ~generic_mode & ~xfer_rd & wt;
  end

endmodule

// File: rtl/tack_arbiter.sv
module tack_arbiter
  import tack_pkg::*;
(
  input  logic ack_oe_n,
  input  logic ext_q_n,
  input  logic access_act,
  input  logic force_hi,
  input  logic entry_invalid,
  input  logic wthru_block,
  input  logic valid_hit,
  output logic ack_n,
  output logic ack_en
);

  tack_src_e src;

  always_comb begin
    if (ack_oe_n)           src = SRC_OFF;
    else if (!ext_q_n)      src = SRC_EXT;
    else if (access_act)    src = SRC_ACCESS;
    else if (force_hi)      src = SRC_FORCE;
    else if (entry_invalid) src = SRC_INVALID;
    else if (wthru_block)   src = SRC_WTHRU;
    else                    src = SRC_CMP;
  end

  always_comb begin
    ack_en = (src != SRC_OFF);
    unique case (src)
      SRC_EXT:   ack_n = 1'b0;
      SRC_FORCE: ack_n = ~valid_hit;
      SRC_CMP:   ack_n = ~valid_hit;
      default:   ack_n = 1'b1;
    endcase
  end

endmodule

// File: rtl/tack_gen.sv
module tack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_oe_n,
  input  logic ext_ack_n,
  input  logic force_hi,
  input  logic xfer_rd,
  input  logic generic_mode,
  input  logic tag_oe_n,
  input  logic tag_we_n,
  input  logic stat_we_n,
  input  logic hit,
  input  logic vld,
  input  logic wt,
  output logic ack_n,
  output logic ack_en
);

  logic ext_q_n;
  logic access_act;
  logic valid_hit;
  logic entry_invalid;
  logic wthru_block;

  assign access_act = ~tag_oe_n | ~tag_we_n | ~stat_we_n;

  tack_ext_sample u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (1'b1),
    .req_n     (ext_ack_n),
    .req_q_n   (ext_q_n)
  );

  tack_qualify u_qual (
    .generic_mode  (generic_mode),
    .hit           (hit),
    .vld           (vld),
    .wt            (wt),
    .xfer_rd       (xfer_rd),
    .valid_hit     (valid_hit),
    .entry_invalid (entry_invalid),
    .wthru_block   (wthru_block)
  );

  tack_arbiter u_arb (
    .ack_oe_n      (ack_oe_n),
    .ext_q_n       (ext_q_n),
    .access_act    (access_act),
    .force_hi      (force_hi),
    .entry_invalid (entry_invalid),
    .wthru_block   (wthru_block),
    .valid_hit     (valid_hit),
    .ack_n         (ack_n),
    .ack_en        (ack_en)
  );

endmodule

// File: rtl/tack_gen_chk.sv
module tack_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_oe_n,
  input logic ext_ack_n,
  input logic force_hi,
  input logic xfer_rd,
  input logic generic_mode,
  input logic tag_oe_n,
  input logic tag_we_n,
  input logic stat_we_n,
  input logic hit,
  input logic vld,
  input logic wt,
  input logic ack_n,
  input logic ack_en
);

  logic armed_q;
  logic quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign quiet = tag_oe_n & tag_we_n & stat_we_n;

  // R1
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_oe_n |-> (!ack_en && ack_n));

  // R2
  ext_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && !$past(ext_ack_n)) |-> (ack_en && !ack_n));

  // R3
  access_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && $past(ext_ack_n) && !quiet) |-> ack_n);

  // R4
  force_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && $past(ext_ack_n) && quiet && force_hi &&
     hit && (generic_mode || vld)) |-> !ack_n);

  // R5
  invalid_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && $past(ext_ack_n) && !generic_mode && !vld) |-> ack_n);

  // R6
  wthru_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && $past(ext_ack_n) && quiet && !force_hi &&
     !generic_mode && !xfer_rd && wt) |-> ack_n);

  // R7
  generic_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !ack_oe_n && $past(ext_ack_n) && quiet && generic_mode) |-> (ack_n == !hit));

endmodule

bind tack_gen tack_gen_chk u_chk (.*);

// File: tb/sim_tack_gen.sv
module sim_tack_gen;

  logic clk = 1'b0;
  logic rst_n;
  logic ack_oe_n, ext_ack_n, force_hi, xfer_rd, generic_mode;
  logic tag_oe_n, tag_we_n, stat_we_n, hit, vld, wt;
  logic ack_n, ack_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tack_gen u0 (.*);

  // Reference: returns {en, ack_n}; rule names the deciding requirement.
  function automatic logic [1:0] ref_out(input logic [10:0] v, output string rule);
    logic oe_n, ex, fh, rd, gm, toe, twe, swe, h, vl, w, qh;
    {oe_n, ex, fh, rd, gm, toe, twe, swe, h, vl, w} = v;
    qh = h && (gm || vl);
    if (oe_n)                 begin rule = "R1"; return 2'b01; end
    if (!ex)                  begin rule = "R2"; return 2'b10; end
    if (!toe || !twe || !swe) begin rule = "R3"; return 2'b11; end
    if (fh)                   begin rule = "R4"; return {1'b1, !qh}; end
    if (!gm && !vl)           begin rule = "R5"; return 2'b11; end
    if (!gm && !rd && w)      begin rule = "R6"; return 2'b11; end
    if (gm)                   begin rule = "R7"; return {1'b1, !h}; end
    rule = "R8";
    return {1'b1, !h};
  endfunction

  task automatic drive(input logic [10:0] v);
    {ack_oe_n, ext_ack_n, force_hi, xfer_rd, generic_mode,
     tag_oe_n, tag_we_n, stat_we_n, hit, vld, wt} = v;
  endtask

  task automatic check(input logic [1:0] exp, input string rule);
    total++;
    if ({ack_en, ack_n} !== exp) begin
      bad++;
      $display("FAIL %s: got en=%b ack_n=%b expected en=%b ack_n=%b",
               rule, ack_en, ack_n, exp[1], exp[0]);
    end
  endtask

  // apply at negedge, ext sampled at next posedge, check at following negedge
  task automatic step(input logic [10:0] v);
    string rule;
    logic [1:0] exp;
    drive(v);
    @(negedge clk);
    exp = ref_out(v, rule);
    check(exp, rule);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    // compare pattern with ext low during reset: enabled, read, dedicated, valid miss
    drive(11'b0_0_0_1_0_1_1_1_0_1_0);
    @(negedge clk);
    @(negedge clk);
    // R9: ext register held inactive, so a miss leaves ack high
    check(2'b11, "R9");
    ack_oe_n = 1'b1;
    #0.1;
    check(2'b01, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    step(11'b0_1_1_0_0_1_1_1_1_1_1); // R4: force with valid hit beats write-through
    step(11'b0_1_1_1_0_1_1_1_1_0_0); // R4: force, hit but invalid
    step(11'b0_1_0_0_0_1_1_1_1_1_1); // R6: write to write-through entry
    step(11'b0_1_0_1_0_1_1_1_1_1_1); // R8: read, valid hit
    step(11'b0_1_0_0_1_1_1_1_1_0_1); // R7: generic ignores vld/wt
    step(11'b0_0_0_1_0_0_1_1_0_0_0); // R2: ext overrides access
    step(11'b0_1_0_1_0_1_1_0_1_1_0); // R3: status write
    step(11'b0_1_0_1_0_1_1_1_1_0_0); // R5: invalid entry

    // exhaustive sweep of all input patterns
    for (int i = 0; i < 2048; i++) step(11'(i));

    // random patterns
    for (int i = 0; i < 1500; i++) step(11'($urandom));

    finish_run();
  end

endmodule